// File: doc/BRIEF.md
# Multi-File Rename Occupancy Tracker

This block keeps count of how many physical entries are in use in each register file that a register renaming stage draws from. There are several files. File 0 is an aggregate default file that is charged for every allocation. Files 1 and up are owning files, each holding a subset of the architectural registers. Every architectural register maps to an owning file index and an entry cost through a fixed table. The table is computed from bit fields of the register ID. Each cycle the renamer may present one allocate request and one free request. Each request carries a register ID and three write flags. The counts move by the register's cost, or stay put when the flags say the write takes no physical entry.

Before it dispatches a group of up to four destination registers, the renamer asks whether they fit. The block adds up the demand per file, compares it with the current counts and the configured capacities, and returns a registered per-file stall bitmask one cycle later. A capacity of zero marks a file as unbounded. A demand larger than a file's whole capacity is clamped, so an oversized group does not deadlock. A free that would take a count below zero sets a sticky error flag.

Top module: `rn_occ_tracker`

## Requirements
- R1: After reset every used count is 0, err_o is 0, rsp_vld_o is 0 and stall_o is 0.
- R2: A register ID maps to owning file areg[5:4] and to cost 2 when areg[1:0] is 2'b11, otherwise cost 1. A charged allocation adds the cost to file 0, and also to the owning file when that index is nonzero. The counts are visible on used_o in the cycle after the request.
- R3: A charged free subtracts the same cost from the same files as an allocation of that register would add to.
- R4: Flag bit 0 (zero idiom) or flag bit 1 (move eliminated) makes an allocate or a free leave every count unchanged.
- R5: A register with areg[3:2] equal to 2'b11 is a narrow alias of a wider register. Its allocate or free changes no count unless flag bit 2 (clears upper bits) is set, and it is then charged as in R2.
- R6: An allocate and a free in the same cycle are both applied, and each file moves by the net difference.
- R7: A free that would make a count negative leaves that count at 0 and sets err_o, which stays 1 until reset.
- R8: For a query, demand in file f is the sum of costs over the slots with their qry_mask_i bit set that charge file f under R2's rule, ignoring the flags. stall_o[f] is 1 when used plus demand exceeds the capacity. rsp_vld_o and stall_o appear in the cycle after qry_vld_i. When rsp_vld_o is 0, stall_o is 0.
- R9: A file whose capacity is 0 never raises its stall bit.
- R10: A demand larger than the capacity of its file is clamped to that capacity before the comparison.
- R11: A count saturates at 255 and does not wrap.
- R12: A query compares against the counts held before any allocate or free presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| file_cap_i | input | 4x8 | Capacity per file, 0 means unbounded |
| alloc_vld_i | input | 1 | Allocate request valid |
| alloc_areg_i | input | 6 | Allocate register ID |
| alloc_flags_i | input | 3 | Allocate flags: bit0 zero idiom, bit1 move eliminated, bit2 clears upper bits |
| free_vld_i | input | 1 | Free request valid |
| free_areg_i | input | 6 | Free register ID |
| free_flags_i | input | 3 | Free flags, same encoding as the allocate flags |
| qry_vld_i | input | 1 | Availability query valid |
| qry_mask_i | input | 4 | Slots taking part in the query |
| qry_areg_i | input | 4x6 | Register ID per query slot |
| rsp_vld_o | output | 1 | Query response valid |
| stall_o | output | 4 | Per-file stall bitmask |
| used_o | output | 4x8 | Used count per file |
| err_o | output | 1 | Sticky underflow error |

## Verification
The bench sweeps every register ID through allocation and free, and every flag combination over several ordinary and narrow-alias registers. A wrong field decode or a missing default-file charge shows up as a count mismatch in file 0 or in the owning file. Randomised queries run against mixed allocations and frees under capacities that include an unbounded file and a tiny one. A design that forgot the clamp would stall forever on an oversized group. A design that compared against already-updated counts would report stalls one cycle early. The bench also pushes a file into underflow and into saturation: a wrapping counter would show 0 or a huge value instead of 0 with the error set, or 255.

// File: rtl/rtrk_pkg.sv
`timescale 1ns/1ps
package rtrk_pkg;
    localparam int NUM_FILES = 4;
    localparam int AREG_W    = 6;
    localparam int CNT_W     = 8;
    localparam int QSLOTS    = 4;
    localparam int FLAG_W    = 3;
    localparam int FIDX_W    = $clog2(NUM_FILES);
    localparam int COST_W    = 2;

    // write qualifiers carried with an allocate or free
    typedef struct packed {
        logic clr_upper;
        logic elim;
        logic zero;
    } wr_flags_t;

    // static rename attributes of one architectural register
    typedef struct packed {
        logic [FIDX_W-1:0] file;
        logic [COST_W-1:0] cost;
        logic              partial;
    } areg_map_t;

    function automatic logic [FIDX_W-1:0] file_of(input logic [AREG_W-1:0] id);
        return id[AREG_W-1 -: FIDX_W];
    endfunction

    function automatic logic [COST_W-1:0] cost_of(input logic [AREG_W-1:0] id);
        return (id[1:0] == 2'b11) ? COST_W'(2) : COST_W'(1);
    endfunction

    function automatic areg_map_t map_areg(input logic [AREG_W-1:0] id);
        areg_map_t m;
        m.file    = file_of(id);
        m.cost    = cost_of(id);
        m.partial = (id[3:2] == 2'b11);
        return m;
    endfunction

    // does a write to this register consume (or release) physical entries
    function automatic logic takes_entries(input areg_map_t m, input wr_flags_t f);
        return !f.zero && !f.elim && !(m.partial && !f.clr_upper);
    endfunction
endpackage

// File: rtl/rt_charge_decode.sv
`timescale 1ns/1ps
module rt_charge_decode
    import rtrk_pkg::*;
#(
    parameter int NFILES = rtrk_pkg::NUM_FILES
) (
    input  logic                           vld_i,
    input  logic [AREG_W-1:0]              areg_i,
    input  logic [FLAG_W-1:0]              flags_i,
    output logic [NFILES-1:0][COST_W-1:0]  delta_o
);
    areg_map_t map;
    logic      charge;

    always_comb begin
        map    = map_areg(areg_i);
        charge = vld_i && takes_entries(map, wr_flags_t'(flags_i));
    end

    for (genvar f = 0; f < NFILES; f++) begin : g_file
        always_comb begin
            if (charge && ((f == 0) || (map.file == FIDX_W'(f))))
                delta_o[f] = map.cost;
            else
                delta_o[f] = '0;
        end
    end
endmodule

// File: rtl/rt_occ_counter.sv
`timescale 1ns/1ps
module rt_occ_counter
    import rtrk_pkg::*;
#(
    parameter int CW = rtrk_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COST_W-1:0] inc_i,
    input  logic [COST_W-1:0] dec_i,
    output logic [CW-1:0]     used_o,
    output logic              under_o
);
    localparam logic [CW:0] MAX_CNT = {1'b0, {CW{1'b1}}};

    logic [CW-1:0] used_q;
    logic [CW:0]   sum;
    logic [CW:0]   diff;
    logic [CW-1:0] used_d;

    always_comb begin
        sum     = {1'b0, used_q} + (CW+1)'(inc_i);
        under_o = sum < (CW+1)'(dec_i);
        diff    = sum - (CW+1)'(dec_i);
        if (under_o)
            used_d = '0;
        else if (diff > MAX_CNT)
            used_d = MAX_CNT[CW-1:0];
        else
            used_d = diff[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) used_q <= '0;
        else     used_q <= used_d;
    end

    assign used_o = used_q;
endmodule

// File: rtl/rt_avail_check.sv
`timescale 1ns/1ps
module rt_avail_check
    import rtrk_pkg::*;
#(
    parameter int NFILES = rtrk_pkg::NUM_FILES,
    parameter int CW     = rtrk_pkg::CNT_W,
    parameter int NSLOT  = rtrk_pkg::QSLOTS
) (
    input  logic [NFILES-1:0][CW-1:0]     used_i,
    input  logic [NFILES-1:0][CW-1:0]     cap_i,
    input  logic [NSLOT-1:0]              mask_i,
    input  logic [NSLOT-1:0][AREG_W-1:0]  areg_i,
    output logic [NFILES-1:0]             stall_o
);
    localparam int SUM_W = CW + 1;

    for (genvar f = 0; f < NFILES; f++) begin : g_file
        logic [SUM_W-1:0] demand;
        logic [SUM_W-1:0] cap_x;
        logic [SUM_W-1:0] dem_c;

        always_comb begin
            demand = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (mask_i[s] && ((f == 0) || (file_of(areg_i[s]) == FIDX_W'(f))))
                    demand = demand + SUM_W'(cost_of(areg_i[s]));
            end
            cap_x      = {1'b0, cap_i[f]};
            dem_c      = (demand > cap_x) ? cap_x : demand;
            stall_o[f] = (cap_i[f] != '0) && (({1'b0, used_i[f]} + dem_c) > cap_x);
        end
    end
endmodule

// File: rtl/rn_occ_tracker.sv
`timescale 1ns/1ps
module rn_occ_tracker
    import rtrk_pkg::*;
#(
    parameter int NFILES = rtrk_pkg::NUM_FILES,
    parameter int CW     = rtrk_pkg::CNT_W,
    parameter int NSLOT  = rtrk_pkg::QSLOTS
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NFILES-1:0][CW-1:0]      file_cap_i,
    input  logic                           alloc_vld_i,
    input  logic [AREG_W-1:0]              alloc_areg_i,
    input  logic [FLAG_W-1:0]              alloc_flags_i,
    input  logic                           free_vld_i,
    input  logic [AREG_W-1:0]              free_areg_i,
    input  logic [FLAG_W-1:0]              free_flags_i,
    input  logic                           qry_vld_i,
    input  logic [NSLOT-1:0]               qry_mask_i,
    input  logic [NSLOT-1:0][AREG_W-1:0]   qry_areg_i,
    output logic                           rsp_vld_o,
    output logic [NFILES-1:0]              stall_o,
    output logic [NFILES-1:0][CW-1:0]      used_o,
    output logic                           err_o
);
    logic [NFILES-1:0][COST_W-1:0] inc;
    logic [NFILES-1:0][COST_W-1:0] dec;
    logic [NFILES-1:0]             under;
    logic [NFILES-1:0]             stall_d;
    logic                          rsp_vld_q;
    logic [NFILES-1:0]             stall_q;
    logic                          err_q;

    rt_charge_decode #(.NFILES(NFILES)) i_alloc_dec (
        .vld_i   (alloc_vld_i),
        .areg_i  (alloc_areg_i),
        .flags_i (alloc_flags_i),
        .delta_o (inc)
    );

    rt_charge_decode #(.NFILES(NFILES)) i_free_dec (
        .vld_i   (free_vld_i),
        .areg_i  (free_areg_i),
        .flags_i (free_flags_i),
        .delta_o (dec)
    );

    for (genvar f = 0; f < NFILES; f++) begin : g_cnt
        rt_occ_counter #(.CW(CW)) i_cnt (
            .clk     (clk),
            .rst     (rst),
            .inc_i   (inc[f]),
            .dec_i   (dec[f]),
            .used_o  (used_o[f]),
            .under_o (under[f])
        );
    end

    rt_avail_check #(.NFILES(NFILES), .CW(CW), .NSLOT(NSLOT)) i_avail (
        .used_i  (used_o),
        .cap_i   (file_cap_i),
        .mask_i  (qry_mask_i),
        .areg_i  (qry_areg_i),
        .stall_o (stall_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld_q <= 1'b0;
            stall_q   <= '0;
            err_q     <= 1'b0;
        end else begin
            rsp_vld_q <= qry_vld_i;
            stall_q   <= qry_vld_i ? stall_d : '0;
            err_q     <= err_q | (|under);
        end
    end

    assign rsp_vld_o = rsp_vld_q;
    assign stall_o   = stall_q;
    assign err_o     = err_q;
endmodule

// File: rtl/rn_occ_tracker_chk.sv
`timescale 1ns/1ps
module rn_occ_tracker_chk
    import rtrk_pkg::*;
#(
    parameter int NFILES = rtrk_pkg::NUM_FILES,
    parameter int CW     = rtrk_pkg::CNT_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NFILES-1:0][CW-1:0] file_cap_i,
    input logic                      alloc_vld_i,
    input logic [FLAG_W-1:0]         alloc_flags_i,
    input logic                      free_vld_i,
    input logic [FLAG_W-1:0]         free_flags_i,
    input logic                      qry_vld_i,
    input logic                      rsp_vld_o,
    input logic [NFILES-1:0]         stall_o,
    input logic [NFILES-1:0][CW-1:0] used_o,
    input logic                      err_o
);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R7
    underflow_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (free_vld_i && !alloc_vld_i && free_flags_i == 3'b100 && used_o[0] == '0) |=> err_o);

    // R8
    rsp_follows_qry_chk: assert property (@(posedge clk) disable iff (rst)
        qry_vld_i |=> rsp_vld_o);

    // R8
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !qry_vld_i |=> !rsp_vld_o);

    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_vld_o |-> (stall_o == '0));

    // R4
    no_req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!alloc_vld_i && !free_vld_i) |=> $stable(used_o));

    // R4
    zero_idiom_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_vld_i && alloc_flags_i[0] && !free_vld_i) |=> $stable(used_o));

    for (genvar f = 0; f < NFILES; f++) begin : g_unb
        // R9
        unbounded_chk: assert property (@(posedge clk) disable iff (rst)
            (qry_vld_i && file_cap_i[f] == '0) |=> !stall_o[f]);
    end
endmodule

bind rn_occ_tracker rn_occ_tracker_chk #(.NFILES(NFILES), .CW(CW)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .file_cap_i    (file_cap_i),
    .alloc_vld_i   (alloc_vld_i),
    .alloc_flags_i (alloc_flags_i),
    .free_vld_i    (free_vld_i),
    .free_flags_i  (free_flags_i),
    .qry_vld_i     (qry_vld_i),
    .rsp_vld_o     (rsp_vld_o),
    .stall_o       (stall_o),
    .used_o        (used_o),
    .err_o         (err_o)
);

// File: tb/test_rn_occ_tracker.sv
`timescale 1ns/1ps
module test_rn_occ_tracker;
    localparam int NF = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NF-1:0][7:0] file_cap = '0;
    logic             alloc_vld = 1'b0;
    logic [5:0]       alloc_areg = '0;
    logic [2:0]       alloc_flags = '0;
    logic             free_vld = 1'b0;
    logic [5:0]       free_areg = '0;
    logic [2:0]       free_flags = '0;
    logic             qry_vld = 1'b0;
    logic [3:0]       qry_mask = '0;
    logic [3:0][5:0]  qry_areg = '0;
    logic             rsp_vld;
    logic [NF-1:0]    stall;
    logic [NF-1:0][7:0] used;
    logic             err;

    int n_chk = 0;
    int n_fail = 0;
    int exp_used [NF];
    bit exp_err = 1'b0;
    int unsigned seed = 32'h1234_5678;

    always #5 clk = ~clk;

    rn_occ_tracker i_rn_occ_tracker (
        .clk           (clk),
        .rst           (rst),
        .file_cap_i    (file_cap),
        .alloc_vld_i   (alloc_vld),
        .alloc_areg_i  (alloc_areg),
        .alloc_flags_i (alloc_flags),
        .free_vld_i    (free_vld),
        .free_areg_i   (free_areg),
        .free_flags_i  (free_flags),
        .qry_vld_i     (qry_vld),
        .qry_mask_i    (qry_mask),
        .qry_areg_i    (qry_areg),
        .rsp_vld_o     (rsp_vld),
        .stall_o       (stall),
        .used_o        (used),
        .err_o         (err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int rnd(input int lim);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % lim);
    endfunction

    function automatic int cost_of(input int r);
        return ((r & 3) == 3) ? 2 : 1;
    endfunction

    function automatic int file_of(input int r);
        return (r >> 4) & 3;
    endfunction

    function automatic bit charged(input int r, input int fl);
        bit partial;
        partial = ((r >> 2) & 3) == 3;
        return !(fl & 1) && !(fl & 2) && !(partial && !(fl & 4));
    endfunction

    function automatic int delta(input bit v, input int r, input int fl, input int f);
        if (v && charged(r, fl) && (f == 0 || file_of(r) == f)) return cost_of(r);
        return 0;
    endfunction

    function automatic int exp_stall(input int qm);
        int res = 0;
        for (int f = 0; f < NF; f++) begin
            int dem = 0;
            int cap = int'(file_cap[f]);
            for (int s = 0; s < 4; s++)
                if (qm[s] && (f == 0 || file_of(int'(qry_areg[s])) == f))
                    dem += cost_of(int'(qry_areg[s]));
            if (cap == 0) continue;
            if (dem > cap) dem = cap;
            if (exp_used[f] + dem > cap) res |= (1 << f);
        end
        return res;
    endfunction

    task automatic check_used(input string tag);
        for (int f = 0; f < NF; f++) check(tag, int'(used[f]), exp_used[f]);
        check({tag, " err"}, int'(err), int'(exp_err));
    endtask

    task automatic cyc(input bit av, input int ar, input int af,
                       input bit fv, input int fr, input int ff,
                       input bit qv, input int qm);
        int qexp;
        alloc_vld = av; alloc_areg = 6'(ar); alloc_flags = 3'(af);
        free_vld = fv;  free_areg = 6'(fr);  free_flags = 3'(ff);
        qry_vld = qv;   qry_mask = 4'(qm);
        qexp = exp_stall(qm);
        @(negedge clk);
        for (int f = 0; f < NF; f++) begin
            int s = exp_used[f] + delta(av, ar, af, f);
            int d = delta(fv, fr, ff, f);
            if (s < d) begin exp_err = 1'b1; exp_used[f] = 0; end
            else begin s = s - d; exp_used[f] = (s > 255) ? 255 : s; end
        end
        check("R8 rsp_vld", int'(rsp_vld), int'(qv));
        check("R8/R12 stall", int'(stall), qv ? qexp : 0);
        alloc_vld = 1'b0; free_vld = 1'b0; qry_vld = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int f = 0; f < NF; f++) exp_used[f] = 0;
        exp_err = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check_used("R1 reset");
        check("R1 rsp_vld", int'(rsp_vld), 0);
        check("R1 stall", int'(stall), 0);

        // R2 sweep every register allocation (flag bit2 so aliases charge too)
        for (int r = 0; r < 64; r++) begin
            cyc(1, r, 4, 0, 0, 0, 0, 0);
            check_used("R2 alloc sweep");
        end
        // R3 free sweep back to zero
        for (int r = 0; r < 64; r++) begin
            cyc(0, 0, 0, 1, r, 4, 0, 0);
            check_used("R3 free sweep");
        end

        // R4 R5 flag sweep over plain and alias registers
        foreach (exp_used[k]) begin end
        for (int i = 0; i < 6; i++) begin
            int r = (i == 0) ? 19 : (i == 1) ? 35 : (i == 2) ? 12 : (i == 3) ? 63 : (i == 4) ? 1 : 46;
            for (int fl = 0; fl < 8; fl++) begin
                cyc(1, r, 4, 0, 0, 0, 0, 0);
                cyc(1, r, fl, 0, 0, 0, 0, 0);
                check_used("R4/R5 alloc flags");
                cyc(0, 0, 0, 1, r, fl, 0, 0);
                check_used("R4/R5 free flags");
                cyc(0, 0, 0, 1, r, 4, 0, 0);
                check_used("R4/R5 restore");
            end
        end

        // R6 simultaneous allocate and free in one file
        cyc(1, 23, 0, 0, 0, 0, 0, 0);
        cyc(1, 17, 0, 1, 23, 0, 0, 0);
        check_used("R6 net change");
        cyc(1, 19, 0, 1, 17, 0, 0, 0);
        check_used("R6 net change");

        // R7 underflow sets sticky error, count floors at zero
        do_reset();
        cyc(0, 0, 0, 1, 35, 0, 0, 0);
        check_used("R7 underflow");
        check("R7 err set", int'(err), 1);
        cyc(1, 35, 0, 0, 0, 0, 0, 0);
        check("R7 err sticky", int'(err), 1);
        do_reset();
        check("R7 err cleared by reset", int'(err), 0);

        // R11 saturation
        for (int i = 0; i < 130; i++) cyc(1, 3, 0, 0, 0, 0, 0, 0);
        check("R11 saturate", int'(used[0]), 255);
        do_reset();

        // R10 clamp and R9 unbounded, directed
        file_cap[0] = 8'd0; file_cap[1] = 8'd6; file_cap[2] = 8'd0; file_cap[3] = 8'd3;
        for (int s = 0; s < 4; s++) qry_areg[s] = 6'(48 + 3);
        cyc(0, 0, 0, 0, 0, 0, 1, 15);
        check("R10 clamped demand no stall", int'(stall[3]), 0);
        check("R9 unbounded file 0", int'(stall[0]), 0);
        cyc(1, 48, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 15);
        check("R10 clamped demand with one used", int'(stall[3]), 1);
        // R12 query same cycle as allocate sees old count
        do_reset();
        for (int s = 0; s < 4; s++) qry_areg[s] = 6'(16);
        cyc(1, 19, 0, 0, 0, 0, 1, 15);
        check("R12 pre-update count", int'(stall[1]), 0);

        // R8 randomised queries with traffic
        file_cap[0] = 8'd12; file_cap[1] = 8'd6; file_cap[2] = 8'd0; file_cap[3] = 8'd3;
        for (int i = 0; i < 400; i++) begin
            for (int s = 0; s < 4; s++) qry_areg[s] = 6'(rnd(64));
            cyc(rnd(3) != 0, rnd(64), (rnd(4) == 0) ? rnd(8) : 4,
                rnd(3) == 0, rnd(64), (rnd(4) == 0) ? rnd(8) : 4,
                rnd(4) != 0, rnd(16));
            check_used("R2/R3/R6 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule